// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for the memory-reference modes of an 8-bit processor core. The instruction sequencer hands it an already decoded mode code, a base-pointer code, an indirect request and up to two operand bytes. It also gives it the live contents of the index pointers, the two stack pointers, the program counter, both 8-bit accumulators and the page register. One clock later the block returns the effective address, a flag that tells the sequencer a further pointer fetch is needed, and an optional request to write an updated value back into the base pointer.

Page-relative and absolute forms ignore the base pointer. The indexed forms add an offset to the selected pointer. The offset can be none, a short 5-bit constant, a signed byte, a full 16-bit word, or one of the accumulators. Two indexed forms step the pointer as a side effect: post-increment uses the old pointer value and pre-decrement uses the new one. All sums wrap around the 64K space. The block does not perform the pointer fetch for indirect accesses. It only flags that one is needed.

Top module: `eagen_top`

## Requirements
- R1: Mode code 0 (page-relative) yields address = {dp_reg, opnd_lo}; base code and opnd_hi have no effect.
- R2: Mode code 1 (absolute) yields address = {opnd_hi, opnd_lo}.
- R3: Base code 0..4 selects ptr_x, ptr_y, ptr_u, ptr_s, ptr_pc. Mode code 2 (indexed, no offset) yields the selected pointer unchanged.
- R4: Mode code 3 adds opnd_lo[4:0], sign-extended (range -16..+15), to the base. opnd_lo[7:5] are ignored.
- R5: Mode code 4 adds opnd_lo, sign-extended (range -128..+127), to the base.
- R6: Mode code 5 adds {opnd_hi, opnd_lo} to the base.
- R7: Mode codes 6 and 7 add acc_a and acc_b, each sign-extended, to the base. Mode code 8 adds the 16-bit pair {acc_a, acc_b}.
- R8: Mode code 9 (post-increment) yields the unmodified base as the address, and requests write-back of base+1 with wb_sel equal to the base code.
- R9: Mode code 10 (pre-decrement) yields base-1 as the address and requests write-back of that same value.
- R10: All address and write-back arithmetic wraps modulo 2^16.
- R11: wb_en is asserted only for modes 9 and 10, and never when the base code is 4 (program counter).
- R12: ea_indirect follows req_indirect for indexed modes (2..10) and is 0 for modes 0 and 1.
- R13: Results appear exactly one clock after req_valid. In a cycle with no request, ea_valid and wb_en are 0. Reset clears ea_valid, ea_indirect and wb_en.
- R14: Mode codes 11..15 never produce ea_valid. An indexed mode with base code 5..7 also never produces ea_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Decoded addressing mode code |
| req_base | input | 3 | Base pointer code |
| req_indirect | input | 1 | Indirect variant requested |
| opnd_hi | input | 8 | First operand byte (high) |
| opnd_lo | input | 8 | Second operand byte (low) |
| dp_reg | input | 8 | Page register |
| acc_a | input | 8 | Accumulator A (high half of the pair) |
| acc_b | input | 8 | Accumulator B (low half of the pair) |
| ptr_x | input | 16 | Index pointer X |
| ptr_y | input | 16 | Index pointer Y |
| ptr_u | input | 16 | User stack pointer |
| ptr_s | input | 16 | System stack pointer |
| ptr_pc | input | 16 | Program counter |
| ea_valid | output | 1 | Result valid |
| ea_addr | output | 16 | Effective address |
| ea_indirect | output | 1 | Sequencer must fetch a pointer from ea_addr |
| wb_en | output | 1 | Base pointer write-back request |
| wb_sel | output | 3 | Base code to write back |
| wb_value | output | 16 | New base pointer value |

## Verification
The hardest situations to reach are the carries across the 64K boundary in the stepping modes. Post-increment from 0xFFFF must write back 0x0000, and pre-decrement from 0x0000 must land on 0xFFFF. Pointer values in normal use never sit there. The bench therefore reloads the pointer inputs with those edge values between requests. It also forces a 16-bit offset whose sum overflows. The suppression of write-back for a program-counter base is reached by requesting post-increment on code 4. The bench confirms that the address still appears while wb_en stays low.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

   typedef enum logic [3:0] {
      AM_PAGE     = 4'd0,
      AM_ABS      = 4'd1,
      AM_IDX_NONE = 4'd2,
      AM_IDX_K5   = 4'd3,
      AM_IDX_K8   = 4'd4,
      AM_IDX_K16  = 4'd5,
      AM_IDX_ACCA = 4'd6,
      AM_IDX_ACCB = 4'd7,
      AM_IDX_ACCD = 4'd8,
      AM_IDX_INC  = 4'd9,
      AM_IDX_DEC  = 4'd10
   } am_mode_e;

   typedef enum logic [2:0] {
      PS_X  = 3'd0,
      PS_Y  = 3'd1,
      PS_U  = 3'd2,
      PS_S  = 3'd3,
      PS_PC = 3'd4
   } ptr_sel_e;

   localparam int unsigned NUM_PTRS = 5;

   function automatic logic mode_known(input logic [3:0] m);
      return m <= 4'd10;
   endfunction

   function automatic logic mode_indexed(input logic [3:0] m);
      return (m >= 4'd2) && (m <= 4'd10);
   endfunction

endpackage

// File: rtl/eagen_base_mux.sv
module eagen_base_mux #(
   parameter int unsigned AW = 16
) (
   input  logic [2:0]    sel,
   input  logic [AW-1:0] ptr_x,
   input  logic [AW-1:0] ptr_y,
   input  logic [AW-1:0] ptr_u,
   input  logic [AW-1:0] ptr_s,
   input  logic [AW-1:0] ptr_pc,
   output logic [AW-1:0] base,
   output logic          base_ok
);
   import eagen_pkg::*;

   logic [NUM_PTRS-1:0][AW-1:0] bank;

   assign bank[PS_X]  = ptr_x;
   assign bank[PS_Y]  = ptr_y;
   assign bank[PS_U]  = ptr_u;
   assign bank[PS_S]  = ptr_s;
   assign bank[PS_PC] = ptr_pc;

   always_comb begin
      base_ok = (32'(sel) < NUM_PTRS);
      base    = '0;
      for (int i = 0; i < NUM_PTRS; i++) begin
         if (32'(sel) == i) base = bank[i];
      end
   end

endmodule

// File: rtl/eagen_offset.sv
module eagen_offset #(
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 8,
   parameter int unsigned K5W        = 5,
   parameter bit          ACC_SIGNED = 1'b1
) (
   input  logic [3:0]    mode,
   input  logic [DW-1:0] opnd_hi,
   input  logic [DW-1:0] opnd_lo,
   input  logic [DW-1:0] acc_a,
   input  logic [DW-1:0] acc_b,
   output logic [AW-1:0] offset
);
   import eagen_pkg::*;

   localparam int unsigned EXT8 = AW - DW;
   localparam int unsigned EXT5 = AW - K5W;

   initial begin
      assert (AW == 2 * DW) else $error("eagen_offset: AW must be twice DW");
      assert (K5W < DW)     else $error("eagen_offset: short offset must be narrower than a byte");
   end

   logic [AW-1:0] ext_a, ext_b, k5_ext, k8_ext;

   generate
      if (ACC_SIGNED) begin : g_acc_signed
         assign ext_a = {{EXT8{acc_a[DW-1]}}, acc_a};
         assign ext_b = {{EXT8{acc_b[DW-1]}}, acc_b};
      end else begin : g_acc_unsigned
         assign ext_a = {{EXT8{1'b0}}, acc_a};
         assign ext_b = {{EXT8{1'b0}}, acc_b};
      end
   endgenerate

   assign k5_ext = {{EXT5{opnd_lo[K5W-1]}}, opnd_lo[K5W-1:0]};
   assign k8_ext = {{EXT8{opnd_lo[DW-1]}}, opnd_lo};

   always_comb begin
      unique case (mode)
         AM_IDX_K5:   offset = k5_ext;
         AM_IDX_K8:   offset = k8_ext;
         AM_IDX_K16:  offset = {opnd_hi, opnd_lo};
         AM_IDX_ACCA: offset = ext_a;
         AM_IDX_ACCB: offset = ext_b;
         AM_IDX_ACCD: offset = {acc_a, acc_b};
         AM_IDX_INC:  offset = AW'(1);
         AM_IDX_DEC:  offset = '1;
         default:     offset = '0;
      endcase
   end

endmodule

// File: rtl/eagen_top.sv
module eagen_top #(
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 8,
   parameter bit          ACC_SIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [3:0]    req_mode,
   input  logic [2:0]    req_base,
   input  logic          req_indirect,
   input  logic [DW-1:0] opnd_hi,
   input  logic [DW-1:0] opnd_lo,
   input  logic [DW-1:0] dp_reg,
   input  logic [DW-1:0] acc_a,
   input  logic [DW-1:0] acc_b,
   input  logic [AW-1:0] ptr_x,
   input  logic [AW-1:0] ptr_y,
   input  logic [AW-1:0] ptr_u,
   input  logic [AW-1:0] ptr_s,
   input  logic [AW-1:0] ptr_pc,
   output logic          ea_valid,
   output logic [AW-1:0] ea_addr,
   output logic          ea_indirect,
   output logic          wb_en,
   output logic [2:0]    wb_sel,
   output logic [AW-1:0] wb_value
);
   import eagen_pkg::*;

   initial begin
      assert (AW == 2 * DW) else $error("eagen_top: AW must be twice DW");
   end

   logic [AW-1:0] base, offset, sum, addr_n;
   logic          base_ok, is_idx, stepping, go, wb_n;

   eagen_base_mux #(.AW(AW)) u_base (
      .sel    (req_base),
      .ptr_x  (ptr_x),
      .ptr_y  (ptr_y),
      .ptr_u  (ptr_u),
      .ptr_s  (ptr_s),
      .ptr_pc (ptr_pc),
      .base   (base),
      .base_ok(base_ok)
   );

   eagen_offset #(.AW(AW), .DW(DW), .ACC_SIGNED(ACC_SIGNED)) u_off (
      .mode   (req_mode),
      .opnd_hi(opnd_hi),
      .opnd_lo(opnd_lo),
      .acc_a  (acc_a),
      .acc_b  (acc_b),
      .offset (offset)
   );

   // single adder shared by every indexed form; wraps naturally at AW bits
   assign sum      = base + offset;
   assign is_idx   = mode_indexed(req_mode);
   assign stepping = (req_mode == AM_IDX_INC) || (req_mode == AM_IDX_DEC);
   assign go       = req_valid && mode_known(req_mode) && (!is_idx || base_ok);
   assign wb_n     = go && stepping && (req_base != PS_PC);

   always_comb begin
      unique case (req_mode)
         AM_PAGE:    addr_n = {dp_reg, opnd_lo};
         AM_ABS:     addr_n = {opnd_hi, opnd_lo};
         AM_IDX_INC: addr_n = base;
         default:    addr_n = sum;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_valid    <= 1'b0;
         ea_indirect <= 1'b0;
         wb_en       <= 1'b0;
         ea_addr     <= '0;
         wb_sel      <= '0;
         wb_value    <= '0;
      end else begin
         ea_valid    <= go;
         ea_indirect <= go && is_idx && req_indirect;
         wb_en       <= wb_n;
         ea_addr     <= addr_n;
         wb_sel      <= req_base;
         wb_value    <= sum;
      end
   end

   // R13: a request with a base-independent mode always produces a result
   p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == AM_PAGE || req_mode == AM_ABS)) |=> ea_valid);

   // R1: page-relative address is the page register joined with the low byte
   p_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && $past(req_mode) == AM_PAGE) |-> ea_addr == {$past(dp_reg), $past(opnd_lo)});

   // R11: write-back only for stepping modes on a non-PC base
   p_wb_only_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (($past(req_mode) == AM_IDX_INC || $past(req_mode) == AM_IDX_DEC)
                 && $past(req_base) != PS_PC && ea_valid));

   // R8: post-increment writes back one past the address used
   p_postinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && $past(req_mode) == AM_IDX_INC) |-> wb_value == AW'(ea_addr + 1'b1));

   // R9: pre-decrement uses and writes back the same value
   p_predec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && $past(req_mode) == AM_IDX_DEC) |-> wb_value == ea_addr);

   // R12: page and absolute forms never flag indirection
   p_no_ind_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_mode) == AM_PAGE || $past(req_mode) == AM_ABS) |-> !ea_indirect);

   // R14: undefined mode codes produce nothing
   p_undef_r14: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_mode) > 4'd10) |-> (!ea_valid && !wb_en));

endmodule

// File: tb/tb_eagen_top.sv
module tb_eagen_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_mode = '0;
   logic [2:0]  req_base = '0;
   logic        req_indirect = 1'b0;
   logic [7:0]  opnd_hi = '0, opnd_lo = '0, dp_reg = '0, acc_a = '0, acc_b = '0;
   logic [15:0] ptr_x = '0, ptr_y = '0, ptr_u = '0, ptr_s = '0, ptr_pc = '0;
   logic        ea_valid, ea_indirect, wb_en;
   logic [15:0] ea_addr, wb_value;
   logic [2:0]  wb_sel;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   eagen_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_base(req_base), .req_indirect(req_indirect), .opnd_hi(opnd_hi),
      .opnd_lo(opnd_lo), .dp_reg(dp_reg), .acc_a(acc_a), .acc_b(acc_b),
      .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u), .ptr_s(ptr_s), .ptr_pc(ptr_pc),
      .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_indirect(ea_indirect),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL R13 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one request, sample one cycle later away from the edge
   task automatic issue(input string req, input logic [3:0] m, input logic [2:0] b,
                        input logic ind, input logic [7:0] hi, input logic [7:0] lo,
                        input logic ev, input logic [15:0] ea, input logic ei,
                        input logic ew, input logic [15:0] wv);
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; req_base = b; req_indirect = ind;
      opnd_hi = hi; opnd_lo = lo;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req, "ea_valid", 16'(ea_valid), 16'(ev));
      if (ev) begin
         check(req, "ea_addr", ea_addr, ea);
         check(req, "ea_indirect", 16'(ea_indirect), 16'(ei));
      end
      check(req, "wb_en", 16'(wb_en), 16'(ew));
      if (ew) begin
         check(req, "wb_value", wb_value, wv);
         check(req, "wb_sel", 16'(wb_sel), 16'(b));
      end
   endtask

   task automatic t_reset;
      check("R13", "reset ea_valid", 16'(ea_valid), 16'd0);
      check("R13", "reset wb_en", 16'(wb_en), 16'd0);
      check("R13", "reset ea_indirect", 16'(ea_indirect), 16'd0);
   endtask

   task automatic t_page_abs;
      issue("R1", 4'd0, 3'd6, 1'b1, 8'h99, 8'h7A, 1, 16'h3C7A, 0, 0, 16'h0);
      issue("R2", 4'd1, 3'd0, 1'b0, 8'hBE, 8'hEF, 1, 16'hBEEF, 0, 0, 16'h0);
   endtask

   task automatic t_bases;
      issue("R3", 4'd2, 3'd0, 1'b0, 8'h00, 8'h00, 1, 16'h1000, 0, 0, 16'h0);
      issue("R3", 4'd2, 3'd1, 1'b0, 8'h00, 8'h00, 1, 16'h2000, 0, 0, 16'h0);
      issue("R3", 4'd2, 3'd2, 1'b0, 8'h00, 8'h00, 1, 16'h3000, 0, 0, 16'h0);
      issue("R3", 4'd2, 3'd3, 1'b0, 8'h00, 8'h00, 1, 16'h4000, 0, 0, 16'h0);
      issue("R3", 4'd2, 3'd4, 1'b0, 8'h00, 8'h00, 1, 16'h5000, 0, 0, 16'h0);
   endtask

   task automatic t_const_offsets;
      issue("R4", 4'd3, 3'd1, 1'b0, 8'h00, 8'h0F, 1, 16'h200F, 0, 0, 16'h0);
      issue("R4", 4'd3, 3'd2, 1'b0, 8'h00, 8'hF0, 1, 16'h2FF0, 0, 0, 16'h0);
      issue("R4", 4'd3, 3'd0, 1'b0, 8'h00, 8'hEF, 1, 16'h100F, 0, 0, 16'h0);
      issue("R5", 4'd4, 3'd3, 1'b0, 8'h00, 8'h80, 1, 16'h3F80, 0, 0, 16'h0);
      issue("R5", 4'd4, 3'd4, 1'b0, 8'h00, 8'h7F, 1, 16'h507F, 0, 0, 16'h0);
      issue("R6", 4'd5, 3'd0, 1'b0, 8'h12, 8'h34, 1, 16'h2234, 0, 0, 16'h0);
   endtask

   task automatic t_acc_offsets;
      issue("R7", 4'd6, 3'd1, 1'b0, 8'h00, 8'h00, 1, 16'h1F85, 0, 0, 16'h0);
      issue("R7", 4'd7, 3'd2, 1'b0, 8'h00, 8'h00, 1, 16'h3012, 0, 0, 16'h0);
      issue("R7", 4'd8, 3'd0, 1'b0, 8'h00, 8'h00, 1, 16'h9512, 0, 0, 16'h0);
   endtask

   task automatic t_stepping;
      issue("R8", 4'd9, 3'd0, 1'b0, 8'h00, 8'h00, 1, 16'h1000, 0, 1, 16'h1001);
      issue("R9", 4'd10, 3'd3, 1'b0, 8'h00, 8'h00, 1, 16'h3FFF, 0, 1, 16'h3FFF);
      issue("R11", 4'd9, 3'd4, 1'b0, 8'h00, 8'h00, 1, 16'h5000, 0, 0, 16'h0);
      issue("R11", 4'd10, 3'd4, 1'b0, 8'h00, 8'h00, 1, 16'h4FFF, 0, 0, 16'h0);
   endtask

   task automatic t_wrap;
      @(negedge clk);
      ptr_x = 16'hFFFF; ptr_u = 16'h0000;
      issue("R10", 4'd9, 3'd0, 1'b0, 8'h00, 8'h00, 1, 16'hFFFF, 0, 1, 16'h0000);
      issue("R10", 4'd10, 3'd2, 1'b0, 8'h00, 8'h00, 1, 16'hFFFF, 0, 1, 16'hFFFF);
      issue("R10", 4'd5, 3'd1, 1'b0, 8'hF0, 8'h00, 1, 16'h1000, 0, 0, 16'h0);
      @(negedge clk);
      ptr_x = 16'h1000; ptr_u = 16'h3000;
   endtask

   task automatic t_indirect;
      issue("R12", 4'd4, 3'd0, 1'b1, 8'h00, 8'h04, 1, 16'h1004, 1, 0, 16'h0);
      issue("R12", 4'd1, 3'd0, 1'b1, 8'h12, 8'h34, 1, 16'h1234, 0, 0, 16'h0);
      issue("R12", 4'd9, 3'd1, 1'b1, 8'h00, 8'h00, 1, 16'h2000, 1, 1, 16'h2001);
   endtask

   task automatic t_idle_and_undefined;
      issue("R14", 4'd11, 3'd0, 1'b0, 8'h00, 8'h00, 0, 16'h0, 0, 0, 16'h0);
      issue("R14", 4'd15, 3'd0, 1'b0, 8'h00, 8'h00, 0, 16'h0, 0, 0, 16'h0);
      issue("R14", 4'd9, 3'd5, 1'b0, 8'h00, 8'h00, 0, 16'h0, 0, 0, 16'h0);
      issue("R14", 4'd2, 3'd7, 1'b0, 8'h00, 8'h00, 0, 16'h0, 0, 0, 16'h0);
      issue("R13", 4'd9, 3'd0, 1'b0, 8'h00, 8'h00, 1, 16'h1000, 0, 1, 16'h1001);
      @(negedge clk);
      check("R13", "idle ea_valid", 16'(ea_valid), 16'd0);
      check("R13", "idle wb_en", 16'(wb_en), 16'd0);
   endtask

   initial begin
      ptr_x = 16'h1000; ptr_y = 16'h2000; ptr_u = 16'h3000;
      ptr_s = 16'h4000; ptr_pc = 16'h5000;
      acc_a = 8'h85; acc_b = 8'h12; dp_reg = 8'h3C;
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_page_abs();
      t_bases();
      t_const_offsets();
      t_acc_offsets();
      t_stepping();
      t_wrap();
      t_indirect();
      t_idle_and_undefined();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule